// File: doc/BRIEF.md
# Frame Sync Activity and Power Controller

This block decides, from pin levels and from whether the frame syncs and the receive bit clock are toggling, whether a voice interface is powered, whether its transmit data pin may be driven, which synchronous transfer mode applies, and whether the channel runs in half-channel form. It runs on the master clock. A free-running counter on that clock splits time into frame windows of `FRAME_TICKS` cycles. All four pins pass through a synchronizer before use.

Power goes off at once when the active-low power-down pin is low. It also goes off when both frame syncs have been low with no edge for `IDLE_FRAMES` whole windows. Power returns only when the power-down pin is high and the transmit frame sync toggled in the window just closed. A wake phase of `PWRUP_FRAMES` windows then keeps the transmit data output released. The receive bit clock works as a mode strap when it is idle. A static low selects sign-extended synchronous mode and a static high selects gain-adjust synchronous mode. Mode and half-channel flags move only at window boundaries, so a transfer in progress never sees them change.

Top module: `fsync_pwr_ctrl`

## Requirements
- R1: While reset is asserted, `powered`, `dt_oe`, `sync_mode`, `gain_mode` and `half_chan` are all 0.
- R2: A low level on `pdn_n` drives `powered` and `dt_oe` to 0 within four clock edges, whatever the sync activity.
- R3: From the off state, `powered` rises only at a window boundary where `pdn_n` is high and `fs_tx` had an edge in that window. Activity on `fs_rx` alone never powers the block.
- R4: After power returns, `dt_oe` stays 0 for at least `PWRUP_FRAMES` (default 2) whole windows. It then rises at a window boundary, and only while `powered` is 1.
- R5: When both frame syncs stay low with no edge for `IDLE_FRAMES` (default 4) consecutive windows, `powered` falls at a window boundary. A shorter idle spell has no effect.
- R6: While `fs_tx` keeps toggling and `pdn_n` is high, power stays on, even if `fs_rx` is idle.
- R7: If `bclk_rx` shows no edge for `IDLE_FRAMES` windows, `sync_mode` becomes 1 and `gain_mode` equals its static level (0 = sign-extended, 1 = gain-adjust). A toggling `bclk_rx` gives `sync_mode` = 0.
- R8: `sync_mode`, `gain_mode` and `half_chan` change only on the clock edge that ends a window. That is every `FRAME_TICKS`-th edge counted from reset release.
- R9: `half_chan` is 1 after a window in which the block was powered, `fs_tx` toggled, and `fs_rx` stayed low with no edge. It clears at the end of the first window in which `fs_rx` toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; sets the frame timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Power-down pin, low = power down |
| fs_tx | input | 1 | Transmit frame sync pin |
| fs_rx | input | 1 | Receive frame sync pin |
| bclk_rx | input | 1 | Receive bit clock pin, doubles as mode strap when idle |
| powered | output | 1 | Block is powered (waking or fully on) |
| dt_oe | output | 1 | Transmit data pin may be driven |
| sync_mode | output | 1 | Receive bit clock idle, so a synchronous mode applies |
| gain_mode | output | 1 | 1 = gain-adjust, 0 = sign-extended synchronous mode |
| half_chan | output | 1 | Receive sync held low while transmit sync runs |

## Verification
A wrong power state appears first on `powered` and `dt_oe`. A missed power-down pin shows within four edges. An error in idle counting moves the off or on point by whole windows, so the bench places its samples between the earliest and latest legal window. A broken window counter or a stray update shows up as a mode or half-channel flag changing on an edge that is not a multiple of the window length, which the bench catches on the first such change. A wrong strap decode shows as a wrong `gain_mode` level once the bit clock has stayed idle for a few windows.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_WAKE = 2'd1,
        PWR_ON   = 2'd2
    } pwr_state_e;

    localparam int SIG_TX  = 0;
    localparam int SIG_RX  = 1;
    localparam int SIG_BCK = 2;
    localparam int NUM_SIG = 3;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/fpc_frame_timer.sv
module fpc_frame_timer #(
    parameter int FRAME_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic frame_end
);
    localparam int CW = (FRAME_TICKS > 1) ? $clog2(FRAME_TICKS) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign frame_end = (cnt_q == CW'(FRAME_TICKS - 1));

    always_comb begin
        cnt_d = frame_end ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fpc_activity.sv
module fpc_activity #(
    parameter int IDLE_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_s,
    input  logic frame_end,
    output logic win_act,
    output logic idle_end
);
    localparam int CW = $clog2(IDLE_FRAMES + 1);

    typedef struct packed {
        logic          prev;
        logic          seen;
        logic [CW-1:0] idle_cnt;
    } act_t;

    act_t st_d, st_q;
    logic tgl;

    assign tgl      = sig_s ^ st_q.prev;
    assign win_act  = st_q.seen | tgl;
    assign idle_end = !win_act && (st_q.idle_cnt >= CW'(IDLE_FRAMES - 1));

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_s;
        if (frame_end) begin
            st_d.seen = 1'b0;
            if (win_act)
                st_d.idle_cnt = '0;
            else if (st_q.idle_cnt != CW'(IDLE_FRAMES))
                st_d.idle_cnt = st_q.idle_cnt + 1'b1;
        end else begin
            st_d.seen = win_act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fsync_pwr_ctrl.sv
module fsync_pwr_ctrl
    import fpc_pkg::*;
#(
    parameter int FRAME_TICKS  = 64,
    parameter int IDLE_FRAMES  = 4,
    parameter int PWRUP_FRAMES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_n,
    input  logic fs_tx,
    input  logic fs_rx,
    input  logic bclk_rx,
    output logic powered,
    output logic dt_oe,
    output logic sync_mode,
    output logic gain_mode,
    output logic half_chan
);
    localparam int WW = (PWRUP_FRAMES > 1) ? $clog2(PWRUP_FRAMES) : 1;

    typedef struct packed {
        pwr_state_e    st;
        logic [WW-1:0] wcnt;
        logic          sync_mode;
        logic          gain;
        logic          half;
    } ctl_t;

    ctl_t               c_d, c_q;
    logic [NUM_SIG:0]   pins_s;
    logic [NUM_SIG-1:0] lvl;
    logic [NUM_SIG-1:0] act;
    logic [NUM_SIG-1:0] idle_e;
    logic               pdn_s;
    logic               frame_end;

    fpc_sync #(.WIDTH(NUM_SIG + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pdn_n, bclk_rx, fs_rx, fs_tx}),
        .dout  (pins_s)
    );

    assign pdn_s = pins_s[NUM_SIG];
    assign lvl   = pins_s[NUM_SIG-1:0];

    fpc_frame_timer #(.FRAME_TICKS(FRAME_TICKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end)
    );

    generate
        for (genvar i = 0; i < NUM_SIG; i++) begin : g_mon
            fpc_activity #(.IDLE_FRAMES(IDLE_FRAMES)) u_act (
                .clk       (clk),
                .rst_n     (rst_n),
                .sig_s     (lvl[i]),
                .frame_end (frame_end),
                .win_act   (act[i]),
                .idle_end  (idle_e[i])
            );
        end
    endgenerate

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            PWR_OFF: begin
                if (pdn_s && frame_end && act[SIG_TX]) begin
                    c_d.st   = PWR_WAKE;
                    c_d.wcnt = '0;
                end
            end
            PWR_WAKE: begin
                if (frame_end) begin
                    if (c_q.wcnt == WW'(PWRUP_FRAMES - 1)) c_d.st = PWR_ON;
                    else                                    c_d.wcnt = c_q.wcnt + 1'b1;
                end
            end
            PWR_ON: begin
                if (frame_end && idle_e[SIG_TX] && idle_e[SIG_RX]
                    && !lvl[SIG_TX] && !lvl[SIG_RX])
                    c_d.st = PWR_OFF;
            end
            default: c_d.st = PWR_OFF;
        endcase
        if (!pdn_s) c_d.st = PWR_OFF;

        if (frame_end) begin
            c_d.sync_mode = idle_e[SIG_BCK];
            c_d.gain      = act[SIG_BCK] ? c_q.gain : lvl[SIG_BCK];
            c_d.half      = (c_q.st != PWR_OFF) && act[SIG_TX]
                            && !act[SIG_RX] && !lvl[SIG_RX];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: PWR_OFF, default: '0};
        else        c_q <= c_d;
    end

    assign powered   = (c_q.st != PWR_OFF);
    assign dt_oe     = (c_q.st == PWR_ON);
    assign sync_mode = c_q.sync_mode;
    assign gain_mode = c_q.gain;
    assign half_chan = c_q.half;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
    input logic clk,
    input logic rst_n,
    input logic pdn_s,
    input logic frame_end,
    input logic powered,
    input logic dt_oe,
    input logic sync_mode,
    input logic gain_mode,
    input logic half_chan
);
    a_r2_pdn_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_s |=> (!powered && !dt_oe));

    a_r3_wake_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(powered) |-> ($past(frame_end) && $past(pdn_s)));

    a_r4_oe_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        dt_oe |-> powered);

    a_r4_oe_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dt_oe) |-> $past(frame_end));

    a_r5_idle_off_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(powered) && $past(pdn_s)) |-> $past(frame_end));

    a_r8_flags_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sync_mode) || !$stable(gain_mode) || !$stable(half_chan))
        |-> $past(frame_end));
endmodule

bind fsync_pwr_ctrl fpc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdn_s     (pdn_s),
    .frame_end (frame_end),
    .powered   (powered),
    .dt_oe     (dt_oe),
    .sync_mode (sync_mode),
    .gain_mode (gain_mode),
    .half_chan (half_chan)
);

// File: tb/tb_fsync_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_fsync_pwr_ctrl;
    localparam int F = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pdn_n = 1'b0;
    logic fs_tx = 1'b0, fs_rx = 1'b0, bclk_rx = 1'b0;
    logic powered, dt_oe, sync_mode, gain_mode, half_chan;

    logic tx_run = 1'b0, rx_run = 1'b0, bclk_run = 1'b0, bclk_lvl = 1'b0;
    int   n_chk = 0, n_fail = 0, ecount = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    fsync_pwr_ctrl #(.FRAME_TICKS(F), .IDLE_FRAMES(4), .PWRUP_FRAMES(2), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .bclk_rx(bclk_rx), .powered(powered), .dt_oe(dt_oe), .sync_mode(sync_mode),
        .gain_mode(gain_mode), .half_chan(half_chan)
    );

    function automatic bit exp_half(bit tx, bit rx, bit pw);
        return pw && tx && !rx;
    endfunction

    function automatic bit exp_sync(bit bck_running);
        return !bck_running;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Pin drivers: sync rising edges exactly F cycles apart while running
    initial forever begin
        if (tx_run) begin
            int w = 1 + int'($urandom % (F / 2));
            fs_tx = 1'b1; wait_cyc(w);
            fs_tx = 1'b0; wait_cyc(F - w);
        end else begin
            fs_tx = 1'b0; wait_cyc(1);
        end
    end

    initial forever begin
        if (rx_run) begin
            int w = 1 + int'($urandom % (F / 2));
            fs_rx = 1'b1; wait_cyc(w);
            fs_rx = 1'b0; wait_cyc(F - w);
        end else begin
            fs_rx = 1'b0; wait_cyc(1);
        end
    end

    initial forever begin
        @(negedge clk);
        bclk_rx = bclk_run ? ~bclk_rx : bclk_lvl;
    end

    // R8 monitor: flags may only change on every F-th edge after reset release
    always @(posedge clk) if (rst_n) ecount++;

    initial begin
        logic [2:0] prev;
        @(posedge rst_n);
        @(negedge clk);
        prev = {sync_mode, gain_mode, half_chan};
        forever begin
            @(negedge clk);
            if ({sync_mode, gain_mode, half_chan} != prev)
                chk((ecount % F) == 0, "R8 flag change edge mod F", ecount % F, 0);
            prev = {sync_mode, gain_mode, half_chan};
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A1B));
        // R1: reset state
        wait_cyc(8);
        chk(powered == 0,   "R1 powered",   powered, 0);
        chk(dt_oe == 0,     "R1 dt_oe",     dt_oe, 0);
        chk(sync_mode == 0, "R1 sync_mode", sync_mode, 0);
        chk(gain_mode == 0, "R1 gain_mode", gain_mode, 0);
        chk(half_chan == 0, "R1 half_chan", half_chan, 0);
        rst_n = 1'b1;
        bclk_run = 1'b1;

        // R3: receive sync alone never wakes the block
        pdn_n = 1'b1; rx_run = 1'b1;
        wait_cyc(6 * F);
        chk(powered == 0, "R3 rx-only wake", powered, 0);

        // R4: transmit sync wakes; dt_oe released for two whole windows
        tx_run = 1'b1;
        begin
            bit early = 1'b0;
            for (int i = 0; i < 2 * F; i++) begin
                wait_cyc(1);
                if (dt_oe) early = 1'b1;
            end
            chk(!early, "R4 dt_oe held off two windows", early, 0);
        end
        wait_cyc(4 * F);
        chk(powered == 1, "R3 powered after tx sync", powered, 1);
        chk(dt_oe == 1,   "R4 dt_oe after wake",     dt_oe, 1);
        chk(sync_mode == exp_sync(1'b1), "R7 toggling bclk", sync_mode, exp_sync(1'b1));

        // R9 / R6: receive sync held low
        rx_run = 1'b0;
        wait_cyc(3 * F);
        chk(half_chan == exp_half(1, 0, powered), "R9 half set", half_chan, exp_half(1, 0, powered));
        chk(powered == 1, "R6 tx keeps power", powered, 1);
        rx_run = 1'b1;
        wait_cyc(3 * F);
        chk(half_chan == exp_half(1, 1, 1), "R9 half clear", half_chan, exp_half(1, 1, 1));

        // R2: power-down pin, random phase, a few rounds
        for (int k = 0; k < 3; k++) begin
            wait_cyc(1 + int'($urandom % F));
            pdn_n = 1'b0;
            wait_cyc(4);
            chk(powered == 0, "R2 powered off", powered, 0);
            chk(dt_oe == 0,   "R2 dt_oe off",   dt_oe, 0);
            wait_cyc(int'($urandom % (2 * F)));
            pdn_n = 1'b1;
            wait_cyc(6 * F);
            chk(dt_oe == 1, "R4 dt_oe back on", dt_oe, 1);
        end

        // R5: both syncs idle
        for (int k = 0; k < 2; k++) begin
            wait_cyc(int'($urandom % F));
            tx_run = 1'b0; rx_run = 1'b0;
            wait_cyc(2 * F);
            chk(powered == 1, "R5 short idle ignored", powered, 1);
            wait_cyc(5 * F);
            chk(powered == 0, "R5 idle power-off", powered, 0);
            wait_cyc(3 * F);
            chk(powered == 0, "R3 stays off without tx", powered, 0);
            tx_run = 1'b1; rx_run = 1'b1;
            wait_cyc(6 * F);
            chk(dt_oe == 1, "R3 tx sync restarts power", dt_oe, 1);
        end

        // R7: bit clock strap levels, directed then random
        for (int k = 0; k < 5; k++) begin
            logic lv = (k < 2) ? logic'(k) : logic'($urandom % 2);
            bclk_run = 1'b0; bclk_lvl = lv;
            wait_cyc(7 * F);
            chk(sync_mode == exp_sync(1'b0), "R7 idle bclk sync_mode", sync_mode, exp_sync(1'b0));
            chk(gain_mode == lv, "R7 strap level", gain_mode, lv);
            bclk_run = 1'b1;
            wait_cyc(3 * F);
            chk(sync_mode == exp_sync(1'b1), "R7 running bclk", sync_mode, exp_sync(1'b1));
        end

        finish_run();
    end
endmodule